// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the hardware steps that a 16-bit processor with a user mode and a supervisor mode performs when it takes an external interrupt, and when it executes the return-from-interrupt instruction. It reads the current program counter, status word and stack pointer (R6) from the register file. It writes them back through write-enable/data pairs, and it moves words through a word-wide memory port with a request/ready handshake.

To take an interrupt, the block first clears the mode bit, which selects supervisor mode. If the interrupted code was in user mode, it parks the user stack pointer in a shadow register and loads R6 from a saved supervisor stack pointer. It then pushes the old status word and then the old program counter, so that the program counter ends on top. Last, it reads the handler address from the vector table and loads it into the program counter. To return, it checks that the processor is in supervisor mode, pops the program counter and then the status word, and swaps the stacks back if the restored status selects user mode. A one-cycle `done` pulse marks the end of either sequence. A return that is attempted from user mode raises `priv_viol` and touches nothing.

Top module: `irq_seq`

## Requirements
- R1: An interrupt starts only while the sequencer is idle, only when both `kbd_ready` and `kbd_ie` are 1, and only when `irq_prio` is strictly greater than `run_prio`. If any of these is false, no memory access and no register write happens.
- R2: One cycle after an interrupt is accepted, the status word is written with bit 15 (the mode bit, 1 = user) cleared. All other bits, including N/Z/P in bits 2..0, keep their values.
- R3: On entry from user mode (old bit 15 = 1), R6 is written with the saved supervisor stack pointer in the same cycle as the status write. The supervisor stack pointer is `SSP_RESET` after reset. The old R6 is kept as the shadow user stack pointer. On entry from supervisor mode, R6 is not swapped.
- R4: Entry writes the old status word to address R6-2 and then the old program counter to R6-4. After each write completes, R6 is written with the address that was just written.
- R5: After the pushes, the word at `VEC_BASE + 2*irq_vector` (0x0200 + 2*vector by default) is read and written to the program counter. `done` pulses in the same cycle as that write.
- R6: A return request made while `psr_in` bit 15 is 1 gives a one-cycle `priv_viol` pulse on the next cycle. No memory access and no register write follows.
- R7: A return in supervisor mode reads the program counter from R6 and writes R6+2 to R6. It then reads the status word from R6+2 and ends with R6 = original R6 + 4, with `done` pulsing alongside the status write.
- R8: If the restored status word has bit 15 = 1, the final R6+4 value becomes the saved supervisor stack pointer, and R6 is written instead with the shadow user stack pointer.
- R9: While a memory request waits for `mem_ready`, the request, direction, address and write data stay unchanged, and no step advances.
- R10: When a return request and an acceptable interrupt arrive in the same idle cycle, the return is performed. Both kinds of request are ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbd_ready | input | 1 | Source has a character pending |
| kbd_ie | input | 1 | Source interrupt enable |
| irq_prio | input | PRIO_W | Priority of the requesting source |
| run_prio | input | PRIO_W | Priority of the running process |
| irq_vector | input | VEC_W | Vector supplied by the source |
| rti_req | input | 1 | Return-from-interrupt request (one-cycle pulse) |
| pc_in | input | W | Current program counter |
| psr_in | input | W | Current status word |
| r6_in | input | W | Current stack pointer R6 |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | W | Program counter write value |
| psr_we | output | 1 | Status word write enable |
| psr_wdata | output | W | Status word write value |
| r6_we | output | 1 | R6 write enable |
| r6_wdata | output | W | R6 write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | W | Memory byte address of the word |
| mem_wdata | output | W | Memory write word |
| mem_rdata | input | W | Memory read word |
| mem_ready | input | 1 | Memory access completes this cycle |
| done | output | 1 | Sequence finished |
| priv_viol | output | 1 | Return attempted in user mode |

## Verification
Entries are tried from user mode and from supervisor mode with different vectors, including the top vector, so that the stack swap can be told apart from a plain push and the vector-table offset can be checked at both ends. Returns are tried to supervisor and to user state, and also from a moved supervisor stack. The later entry then shows that the supervisor pointer was saved where the return left it. Request patterns that miss one acceptance condition, a return made in user mode, requests arriving during a busy sequence and a return colliding with an interrupt separate the gating rules from the sequencing. Memory latency is varied from zero to three wait cycles so that a step advancing without `mem_ready` would show up.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_PSR,
        S_PUSH_PC,
        S_VEC,
        S_POP_PC,
        S_POP_PSR
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic [15:0] sp;
        logic [15:0] ssp;
        logic [15:0] usp;
        logic [15:0] old_psr;
        logic [15:0] old_pc;
        logic [7:0]  vec;
        logic        pc_we;
        logic [15:0] pc_wd;
        logic        psr_we;
        logic [15:0] psr_wd;
        logic        r6_we;
        logic [15:0] r6_wd;
        logic        done;
        logic        viol;
    } seq_regs_t;

endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
    parameter int PRIO_W = 3
) (
    input  logic              src_ready,
    input  logic              src_ie,
    input  logic [PRIO_W-1:0] src_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    output logic              take
);
    always_comb begin
        take = src_ready && src_ie && (src_prio > cur_prio);
    end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int          W        = 16,
    parameter int          VEC_W    = 8,
    parameter logic [15:0] VEC_BASE = 16'h0200
) (
    input  logic [VEC_W-1:0] vec,
    output logic [W-1:0]     addr
);
    localparam int OFS_W = VEC_W + 1;

    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs  = {vec, 1'b0};
        addr = W'(VEC_BASE) + W'(ofs);
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int          W         = 16,
    parameter int          PRIO_W    = 3,
    parameter int          VEC_W     = 8,
    parameter logic [15:0] VEC_BASE  = 16'h0200,
    parameter logic [15:0] SSP_RESET = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_ready,
    input  logic              kbd_ie,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic [VEC_W-1:0]  irq_vector,
    input  logic              rti_req,
    input  logic [W-1:0]      pc_in,
    input  logic [W-1:0]      psr_in,
    input  logic [W-1:0]      r6_in,
    output logic              pc_we,
    output logic [W-1:0]      pc_wdata,
    output logic              psr_we,
    output logic [W-1:0]      psr_wdata,
    output logic              r6_we,
    output logic [W-1:0]      r6_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              priv_viol
);
    localparam int     MODE_BIT = W - 1;
    localparam logic [W-1:0] STEP     = W'(2);
    localparam logic [W-1:0] MODE_CLR = ~(W'(1) << MODE_BIT);

    seq_regs_t r_q, r_d;
    logic      take;
    logic [W-1:0] vec_addr;

    irq_accept #(.PRIO_W(PRIO_W)) u_accept (
        .src_ready (kbd_ready),
        .src_ie    (kbd_ie),
        .src_prio  (irq_prio),
        .cur_prio  (run_prio),
        .take      (take)
    );

    irq_vec_addr #(.W(W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec (
        .vec  (r_q.vec),
        .addr (vec_addr)
    );

    always_comb begin
        r_d        = r_q;
        r_d.pc_we  = 1'b0;
        r_d.psr_we = 1'b0;
        r_d.r6_we  = 1'b0;
        r_d.done   = 1'b0;
        r_d.viol   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        case (r_q.state)
            S_IDLE: begin
                if (rti_req) begin
                    if (psr_in[MODE_BIT]) begin
                        r_d.viol = 1'b1;
                    end else begin
                        r_d.sp    = r6_in;
                        r_d.state = S_POP_PC;
                    end
                end else if (take) begin
                    r_d.old_psr = psr_in;
                    r_d.old_pc  = pc_in;
                    r_d.vec     = irq_vector;
                    r_d.psr_we  = 1'b1;
                    r_d.psr_wd  = psr_in & MODE_CLR;
                    if (psr_in[MODE_BIT]) begin
                        r_d.usp   = r6_in;
                        r_d.sp    = r_q.ssp;
                        r_d.r6_we = 1'b1;
                        r_d.r6_wd = r_q.ssp;
                    end else begin
                        r_d.sp = r6_in;
                    end
                    r_d.state = S_PUSH_PSR;
                end
            end
            S_PUSH_PSR, S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - STEP;
                mem_wdata = (r_q.state == S_PUSH_PSR) ? r_q.old_psr : r_q.old_pc;
                if (mem_ready) begin
                    r_d.sp    = r_q.sp - STEP;
                    r_d.r6_we = 1'b1;
                    r_d.r6_wd = r_q.sp - STEP;
                    r_d.state = (r_q.state == S_PUSH_PSR) ? S_PUSH_PC : S_VEC;
                end
            end
            S_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
                if (mem_ready) begin
                    r_d.pc_we = 1'b1;
                    r_d.pc_wd = mem_rdata;
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                end
            end
            S_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                if (mem_ready) begin
                    r_d.pc_we = 1'b1;
                    r_d.pc_wd = mem_rdata;
                    r_d.sp    = r_q.sp + STEP;
                    r_d.r6_we = 1'b1;
                    r_d.r6_wd = r_q.sp + STEP;
                    r_d.state = S_POP_PSR;
                end
            end
            S_POP_PSR: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                if (mem_ready) begin
                    r_d.psr_we = 1'b1;
                    r_d.psr_wd = mem_rdata;
                    r_d.sp     = r_q.sp + STEP;
                    r_d.r6_we  = 1'b1;
                    if (mem_rdata[MODE_BIT]) begin
                        r_d.ssp   = r_q.sp + STEP;
                        r_d.r6_wd = r_q.usp;
                    end else begin
                        r_d.r6_wd = r_q.sp + STEP;
                    end
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
            r_q.ssp   <= SSP_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_we     = r_q.pc_we;
    assign pc_wdata  = r_q.pc_wd;
    assign psr_we    = r_q.psr_we;
    assign psr_wdata = r_q.psr_wd;
    assign r6_we     = r_q.r6_we;
    assign r6_wdata  = r_q.r6_wd;
    assign done      = r_q.done;
    assign priv_viol = r_q.viol;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R4
    push_predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (r6_we && r6_wdata == $past(mem_addr)));

    // R6
    viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> (!pc_we && !psr_we && !r6_we && !done));

    // R5
    done_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pc_we || psr_we));

    // R10
    busy_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> !priv_viol);
endmodule

// File: tb/irq_seq_test.sv
`timescale 1ns/1ps
module irq_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kbd_ready = 1'b0, kbd_ie = 1'b0;
    logic [2:0]  irq_prio = '0, run_prio = '0;
    logic [7:0]  irq_vector = '0;
    logic        rti_req = 1'b0;
    logic [15:0] pc_r = '0, psr_r = '0, r6_r = '0;
    logic        pc_we, psr_we, r6_we;
    logic [15:0] pc_wdata, psr_wdata, r6_wdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        done, priv_viol;

    int checks = 0, failures = 0;
    int lat = 0, cnt = 0;
    logic [15:0] mem [int];

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
        string       tag;
    } acc_t;
    acc_t exp_q[$];

    irq_seq uut (
        .clk(clk), .rst_n(rst_n), .kbd_ready(kbd_ready), .kbd_ie(kbd_ie),
        .irq_prio(irq_prio), .run_prio(run_prio), .irq_vector(irq_vector),
        .rti_req(rti_req), .pc_in(pc_r), .psr_in(psr_r), .r6_in(r6_r),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .psr_we(psr_we), .psr_wdata(psr_wdata),
        .r6_we(r6_we), .r6_wdata(r6_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .done(done), .priv_viol(priv_viol)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_acc(logic we, logic [15:0] addr, logic [15:0] data, string tag);
        acc_t a;
        a.we = we; a.addr = addr; a.data = data; a.tag = tag;
        exp_q.push_back(a);
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_ready = 1'b1;
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R10 unexpected access actual=%h expected=none", mem_addr);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " dir"}, {15'd0, mem_we}, {15'd0, e.we});
                    chk({e.tag, " addr"}, mem_addr, e.addr);
                    if (e.we) chk({e.tag, " wdata"}, mem_wdata, e.data);
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                else mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
            end else begin
                cnt++;
            end
        end
    end

    // register file model
    always @(negedge clk) begin
        if (pc_we)  pc_r  = pc_wdata;
        if (psr_we) psr_r = psr_wdata;
        if (r6_we)  r6_r  = r6_wdata;
    end

    task automatic wait_done(string tag);
        bit seen = 0;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            if (done) begin seen = 1; break; end
        end
        chk({tag, " done"}, {15'd0, seen}, 16'd1);
        chk({tag, " queue drained"}, 16'(exp_q.size()), 16'd0);
    endtask

    task automatic start_irq(logic [7:0] v);
        kbd_ready = 1; kbd_ie = 1; irq_prio = 3'd4; run_prio = 3'd0; irq_vector = v;
        @(negedge clk); #1;
        kbd_ready = 0;
    endtask

    task automatic pulse_rti();
        rti_req = 1;
        @(negedge clk); #1;
        rti_req = 0;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit quiet;
        repeat (3) @(negedge clk);
        #1;
        chk("reset mem_req", {15'd0, mem_req}, 16'd0);
        chk("reset done", {15'd0, done}, 16'd0);
        chk("reset writes", {13'd0, pc_we, psr_we, r6_we}, 16'd0);
        rst_n = 1;
        @(negedge clk); #1;

        // user-mode entry, zero latency
        lat = 0;
        pc_r = 16'h3050; psr_r = 16'h8001; r6_r = 16'h4000;
        mem[16'h0280] = 16'h1200;
        expect_acc(1, 16'h2FFE, 16'h8001, "R4 push psr");
        expect_acc(1, 16'h2FFC, 16'h3050, "R4 push pc");
        expect_acc(0, 16'h0280, 16'h0, "R5 vector read");
        start_irq(8'h40);
        chk("R2 mode cleared, ccodes kept", psr_r, 16'h0001);
        chk("R3 r6 swapped to ssp", r6_r, 16'h3000);
        wait_done("R5 user entry");
        chk("R5 pc loaded", pc_r, 16'h1200);
        chk("R4 final r6", r6_r, 16'h2FFC);

        // return to user, latency 1
        lat = 1;
        expect_acc(0, 16'h2FFC, 16'h0, "R7 pop pc");
        expect_acc(0, 16'h2FFE, 16'h0, "R7 pop psr");
        pulse_rti();
        wait_done("R7 return");
        chk("R7 pc restored", pc_r, 16'h3050);
        chk("R7 psr restored", psr_r, 16'h8001);
        chk("R8 r6 from shadow usp", r6_r, 16'h4000);

        // return in user mode
        rti_req = 1;
        @(negedge clk); #1;
        rti_req = 0;
        chk("R6 viol pulse", {15'd0, priv_viol}, 16'd1);
        quiet = 1;
        repeat (4) begin @(negedge clk); #1; if (mem_req || priv_viol || psr_we || pc_we) quiet = 0; end
        chk("R6 no activity", {15'd0, quiet}, 16'd1);
        chk("R6 psr unchanged", psr_r, 16'h8001);

        // rejected requests
        quiet = 1;
        kbd_ready = 1; kbd_ie = 0; irq_prio = 3'd4; run_prio = 3'd0;
        repeat (3) begin @(negedge clk); #1; if (mem_req || psr_we || r6_we) quiet = 0; end
        kbd_ready = 0; kbd_ie = 1;
        repeat (3) begin @(negedge clk); #1; if (mem_req || psr_we || r6_we) quiet = 0; end
        kbd_ready = 1; kbd_ie = 1; irq_prio = 3'd2; run_prio = 3'd2;
        repeat (3) begin @(negedge clk); #1; if (mem_req || psr_we || r6_we) quiet = 0; end
        kbd_ready = 0; kbd_ie = 0;
        chk("R1 rejects ignored", {15'd0, quiet}, 16'd1);
        chk("R1 psr unchanged", psr_r, 16'h8001);

        // supervisor entry, latency 3, requests during busy ignored
        lat = 3;
        pc_r = 16'h1300; psr_r = 16'h0004; r6_r = 16'h2F00;
        mem[16'h0202] = 16'h1500;
        expect_acc(1, 16'h2EFE, 16'h0004, "R4 sup push psr");
        expect_acc(1, 16'h2EFC, 16'h1300, "R4 sup push pc");
        expect_acc(0, 16'h0202, 16'h0, "R5 sup vector read");
        start_irq(8'h01);
        chk("R3 no swap in supervisor", r6_r, 16'h2F00);
        @(negedge clk); #1;
        rti_req = 1; kbd_ready = 1;
        @(negedge clk); #1;
        rti_req = 0; kbd_ready = 0;
        wait_done("R10 busy entry");
        chk("R5 sup pc", pc_r, 16'h1500);
        chk("R9 sup final r6", r6_r, 16'h2EFC);

        // return staying in supervisor
        lat = 2;
        expect_acc(0, 16'h2EFC, 16'h0, "R7 sup pop pc");
        expect_acc(0, 16'h2EFE, 16'h0, "R7 sup pop psr");
        pulse_rti();
        wait_done("R7 sup return");
        chk("R7 sup pc", pc_r, 16'h1300);
        chk("R7 sup psr", psr_r, 16'h0004);
        chk("R7 sup r6 +4", r6_r, 16'h2F00);

        // return to user from moved supervisor stack
        lat = 0;
        r6_r = 16'h2800; psr_r = 16'h0000;
        mem[16'h2800] = 16'h3100; mem[16'h2802] = 16'h8002;
        expect_acc(0, 16'h2800, 16'h0, "R8 pop pc");
        expect_acc(0, 16'h2802, 16'h0, "R8 pop psr");
        pulse_rti();
        wait_done("R8 return");
        chk("R8 r6 usp", r6_r, 16'h4000);
        chk("R8 psr", psr_r, 16'h8002);

        // entry uses the saved ssp, top vector
        mem[16'h03FE] = 16'h1700;
        expect_acc(1, 16'h2802, 16'h8002, "R8 ssp saved push psr");
        expect_acc(1, 16'h2800, 16'h3100, "R8 ssp saved push pc");
        expect_acc(0, 16'h03FE, 16'h0, "R5 top vector read");
        start_irq(8'hFF);
        chk("R8 r6 = saved ssp", r6_r, 16'h2804);
        wait_done("R8 entry");
        chk("R5 top vector pc", pc_r, 16'h1700);
        chk("R2 psr user entry", psr_r, 16'h0002);

        // simultaneous return and interrupt: return wins
        lat = 1;
        expect_acc(0, 16'h2800, 16'h0, "R10 pop pc first");
        expect_acc(0, 16'h2802, 16'h0, "R10 pop psr");
        kbd_ready = 1; kbd_ie = 1; irq_prio = 3'd5; run_prio = 3'd1; rti_req = 1;
        @(negedge clk); #1;
        kbd_ready = 0; rti_req = 0;
        wait_done("R10 collide");
        chk("R10 pc", pc_r, 16'h3100);
        chk("R10 r6", r6_r, 16'h4000);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule